// File: doc/BRIEF.md
# Vectored Interrupt Prioritizer

This block collects up to 64 raw interrupt request lines from peripherals and turns them into two CPU request levels, a fast one and a normal one. A rising edge on a request line sets a pending flag for that channel. Each channel is routed either to the fast queue or to the normal queue, and it can be masked. The block drives the fast and normal requests whenever an enabled channel in that queue is pending. For the normal queue it also chooses a single winner by fixed priority and presents that channel's service routine address, which it reads from an internal table. The CPU can then branch to the handler without scanning pending bits in software.

Software uses a simple word-addressed register bus. Through it, software loads the address table, routes channels to the fast queue, masks and unmasks channels through separate set and clear words, and acknowledges pending flags by writing ones. Two channels, 0 and 1, are permanently unmasked and permanently routed to the fast queue. The address table has one extra word at its start. The block outputs that word when no normal-queue channel is ready.

Top module: `intr_vector_mgr`

## Requirements
- R1: A channel's pending flag sets on the clock after its request line rises, sampled synchronously. A line held high sets the flag only once, and after the flag is acknowledged it does not set again until the line falls and rises again.
- R2: Writing a word to a flag group address (0x86 for channels 0-31, 0x87 for 32-63) clears each flag whose bit is 1 and leaves the flags under 0 bits alone. If a rising request and a clear for the same channel come in the same cycle, the flag stays set. Reading that address returns the flags.
- R3: A 1 written to the unmask-set group (0x82/0x83) unmasks the channel under that bit, and a 1 written to the unmask-clear group (0x84/0x85) masks it. A 0 bit changes nothing. Reading either group returns the current unmask vector.
- R4: Channels 0 and 1 always read as unmasked and as fast-queue channels (bits 1:0 of 0x80 and 0x82 read 1), whatever is written to them.
- R5: In the route group (0x80/0x81), a 1 bit sends the channel to the fast queue and a 0 bit sends it to the normal queue. After reset every channel except 0 and 1 is in the normal queue.
- R6: A masked channel still sets its pending flag but drives no CPU request. If the channel is unmasked later while its flag is still set, the request appears.
- R7: `fiq_o` and `irq_o` are registered levels. Each is the OR of the pending, unmasked channels in its queue, and it follows a flag change by one clock.
- R8: Among the pending, unmasked normal-queue channels, the lowest channel number wins. `irq_slot_o` gives the winner's number plus one, or 0 when there is no winner. It updates in the same cycle as `irq_o`.
- R9: `irq_vec_o` holds the table word whose index is `irq_slot_o`, aligned to the same cycle. Word 0 is the idle vector.
- R10: Table words 0 to 64 sit at bus addresses 0x00 to 0x40. Software can write and read them back. All bus reads return data one clock after the address is presented.
- R11: After reset no flag is pending, both CPU requests are low, `irq_slot_o` is 0, and only channels 0 and 1 are unmasked.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_we | input | 1 | Write strobe for the register bus |
| bus_addr | input | ADDR_W | Word address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, one clock after the address |
| req_i | input | NCH | Raw interrupt request lines |
| fiq_o | output | 1 | Fast-queue CPU request |
| irq_o | output | 1 | Normal-queue CPU request |
| irq_slot_o | output | SW | Winning channel number plus one, 0 when idle |
| irq_vec_o | output | 32 | Service routine address of the winner |

## Verification
The hardest case to reach from the ports is a new request edge arriving in the very cycle that software acknowledges the same channel. The bench gets there by driving the request rise and the clear write together on one falling edge, after the flag has already been set once. Priority ordering is exercised by firing 62 channels at once and then acknowledging the winners one at a time, checking each successor. A per-channel sweep walks every normal-queue channel through unmask, fire, vector check and acknowledge.

// File: rtl/vim_pkg.sv
package vim_pkg;
  // Register groups above the vector table, each NCH/32 words long.
  typedef enum logic [1:0] {
    GRP_ROUTE = 2'd0,
    GRP_USET  = 2'd1,
    GRP_UCLR  = 2'd2,
    GRP_FLAG  = 2'd3
  } grp_e;

  localparam int unsigned DATA_W = 32;
  localparam int unsigned FIXED_FAST = 2;  // channels hard-wired to fast queue
endpackage

// File: rtl/vim_flags.sv
module vim_flags #(
  parameter int unsigned NCH = 64
) (
  input  logic           clk,
  input  logic           rst,
  input  logic [NCH-1:0] req_i,
  input  logic [NCH-1:0] clr_i,
  output logic [NCH-1:0] flag_o
);
  logic [NCH-1:0] prev_q;
  logic [NCH-1:0] flag_q;
  logic [NCH-1:0] rise;

  assign rise = req_i & ~prev_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      prev_q <= '0;
      flag_q <= '0;
    end else begin
      prev_q <= req_i;
      // a fresh edge wins over an acknowledge in the same cycle
      flag_q <= (flag_q & ~clr_i) | rise;
    end
  end

  assign flag_o = flag_q;
endmodule

// File: rtl/vim_prio.sv
module vim_prio #(
  parameter int unsigned NCH = 64,
  localparam int unsigned IW = $clog2(NCH)
) (
  input  logic [NCH-1:0] act_i,
  output logic           any_o,
  output logic [IW-1:0]  idx_o
);
  always_comb begin
    idx_o = '0;
    for (int i = NCH - 1; i >= 0; i--) begin
      if (act_i[i]) idx_o = IW'(i);
    end
  end

  assign any_o = |act_i;
endmodule

// File: rtl/vim_vtable.sv
module vim_vtable #(
  parameter int unsigned DEPTH = 65,
  parameter int unsigned DW    = 32,
  localparam int unsigned AW   = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          we_i,
  input  logic [AW-1:0] waddr_i,
  input  logic [DW-1:0] wdata_i,
  input  logic [AW-1:0] raddr_a_i,
  output logic [DW-1:0] rdata_a_o,
  input  logic [AW-1:0] raddr_b_i,
  output logic [DW-1:0] rdata_b_o
);
  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we_i) mem[waddr_i] <= wdata_i;
  end

  always_ff @(posedge clk) rdata_a_o <= mem[raddr_a_i];
  always_ff @(posedge clk) rdata_b_o <= mem[raddr_b_i];
endmodule

// File: rtl/intr_vector_mgr.sv
module intr_vector_mgr
  import vim_pkg::*;
#(
  parameter int unsigned NCH    = 64,
  parameter int unsigned ADDR_W = 8,
  localparam int unsigned SW    = $clog2(NCH + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_we,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  input  logic [NCH-1:0]    req_i,
  output logic              fiq_o,
  output logic              irq_o,
  output logic [SW-1:0]     irq_slot_o,
  output logic [31:0]       irq_vec_o
);
  localparam int unsigned NW       = NCH / DATA_W;
  localparam int unsigned TW       = NCH + 1;
  localparam int unsigned TAW      = $clog2(TW);
  localparam int unsigned REG_BASE = 1 << TAW;
  localparam int unsigned IW       = $clog2(NCH);
  localparam logic [NCH-1:0] FIX_MASK = NCH'((1 << FIXED_FAST) - 1);

  // ---------------- bus decode ----------------
  logic       tbl_hit, reg_hit;
  grp_e       grp;
  int         word;
  always_comb begin
    int off;
    off     = int'(bus_addr) - int'(REG_BASE);
    tbl_hit = int'(bus_addr) < int'(TW);
    reg_hit = (off >= 0) && (off < int'(4 * NW));
    grp     = grp_e'(reg_hit ? 2'(off / int'(NW)) : 2'd0);
    word    = reg_hit ? off % int'(NW) : 0;
  end

  // ---------------- control state ----------------
  logic [NCH-1:0] route_q, unmask_q, route_n, unmask_n, clr_mask;
  logic [NCH-1:0] flags;

  always_comb begin
    route_n  = route_q;
    unmask_n = unmask_q;
    clr_mask = '0;
    if (bus_we && reg_hit) begin
      unique case (grp)
        GRP_ROUTE: route_n[word*DATA_W +: DATA_W] = bus_wdata;
        GRP_USET:  unmask_n[word*DATA_W +: DATA_W] = unmask_q[word*DATA_W +: DATA_W] | bus_wdata;
        GRP_UCLR:  unmask_n[word*DATA_W +: DATA_W] = unmask_q[word*DATA_W +: DATA_W] & ~bus_wdata;
        GRP_FLAG:  clr_mask[word*DATA_W +: DATA_W] = bus_wdata;
        default: ;
      endcase
    end
    route_n  = route_n | FIX_MASK;
    unmask_n = unmask_n | FIX_MASK;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      route_q  <= FIX_MASK;
      unmask_q <= FIX_MASK;
    end else begin
      route_q  <= route_n;
      unmask_q <= unmask_n;
    end
  end

  vim_flags #(.NCH(NCH)) u_flags (
    .clk   (clk),
    .rst   (rst),
    .req_i (req_i),
    .clr_i (clr_mask),
    .flag_o(flags)
  );

  // ---------------- prioritization ----------------
  logic [NCH-1:0] act_irq, act_fiq;
  logic           any_irq;
  logic [IW-1:0]  win_idx;
  logic [SW-1:0]  slot_n;

  assign act_irq = flags & unmask_q & ~route_q;
  assign act_fiq = flags & unmask_q & route_q;

  vim_prio #(.NCH(NCH)) u_prio (
    .act_i(act_irq),
    .any_o(any_irq),
    .idx_o(win_idx)
  );

  assign slot_n = any_irq ? SW'(win_idx) + SW'(1) : '0;

  logic          fiq_q, irq_q;
  logic [SW-1:0] slot_q;
  always_ff @(posedge clk) begin
    if (rst) begin
      fiq_q  <= 1'b0;
      irq_q  <= 1'b0;
      slot_q <= '0;
    end else begin
      fiq_q  <= |act_fiq;
      irq_q  <= any_irq;
      slot_q <= slot_n;
    end
  end

  // ---------------- vector table ----------------
  logic [TAW-1:0] tbl_raddr;
  logic [31:0]    tbl_rdata;
  assign tbl_raddr = tbl_hit ? bus_addr[TAW-1:0] : '0;

  vim_vtable #(.DEPTH(TW), .DW(DATA_W)) u_tbl (
    .clk      (clk),
    .we_i     (bus_we && tbl_hit),
    .waddr_i  (bus_addr[TAW-1:0]),
    .wdata_i  (bus_wdata),
    .raddr_a_i(tbl_raddr),
    .rdata_a_o(tbl_rdata),
    .raddr_b_i(TAW'(slot_n)),
    .rdata_b_o(irq_vec_o)
  );

  // ---------------- register readback ----------------
  logic [31:0] reg_rd_q;
  logic        tbl_hit_q;
  always_ff @(posedge clk) begin
    if (rst) begin
      reg_rd_q  <= '0;
      tbl_hit_q <= 1'b0;
    end else begin
      tbl_hit_q <= tbl_hit;
      reg_rd_q  <= '0;
      if (reg_hit) begin
        unique case (grp)
          GRP_ROUTE:          reg_rd_q <= route_q[word*DATA_W +: DATA_W];
          GRP_USET, GRP_UCLR: reg_rd_q <= unmask_q[word*DATA_W +: DATA_W];
          GRP_FLAG:           reg_rd_q <= flags[word*DATA_W +: DATA_W];
          default: ;
        endcase
      end
    end
  end

  assign bus_rdata  = tbl_hit_q ? tbl_rdata : reg_rd_q;
  assign fiq_o      = fiq_q;
  assign irq_o      = irq_q;
  assign irq_slot_o = slot_q;
endmodule

// File: rtl/vim_chk.sv
module vim_chk #(
  parameter int unsigned NCH = 64,
  parameter int unsigned SW  = 7
) (
  input logic           clk,
  input logic           rst,
  input logic [NCH-1:0] req_i,
  input logic [NCH-1:0] flags,
  input logic [NCH-1:0] unmask,
  input logic [NCH-1:0] route,
  input logic           fiq_o,
  input logic           irq_o,
  input logic [SW-1:0]  slot
);
  // R7: normal request follows pending-and-unmasked normal channels by one clock
  a_r7_irq_level: assert property (@(posedge clk) disable iff (rst)
    irq_o == $past(|(flags & unmask & ~route)));

  // R7: fast request follows pending-and-unmasked fast channels by one clock
  a_r7_fiq_level: assert property (@(posedge clk) disable iff (rst)
    fiq_o == $past(|(flags & unmask & route)));

  // R4: the two lowest channels stay unmasked and fast
  a_r4_fixed_low: assert property (@(posedge clk) disable iff (rst)
    (unmask[1:0] == 2'b11) && (route[1:0] == 2'b11));

  // R8: a nonzero slot exactly when the normal request is up
  a_r8_slot_match: assert property (@(posedge clk) disable iff (rst)
    irq_o == (slot != '0));

  // R1: a rising request line sets its flag on the next clock
  for (genvar g = 0; g < NCH; g++) begin : g_edge
    a_r1_edge_sets: assert property (@(posedge clk) disable iff (rst)
      $rose(req_i[g]) |=> flags[g]);
  end
endmodule

bind intr_vector_mgr vim_chk #(.NCH(NCH), .SW(SW)) u_chk (
  .clk   (clk),
  .rst   (rst),
  .req_i (req_i),
  .flags (flags),
  .unmask(unmask_q),
  .route (route_q),
  .fiq_o (fiq_o),
  .irq_o (irq_o),
  .slot  (irq_slot_o)
);

// File: tb/tb_intr_vector_mgr.sv
module tb_intr_vector_mgr;
  localparam int NCH = 64;
  localparam int SW  = 7;
  localparam logic [7:0] A_ROUTE = 8'h80, A_USET = 8'h82, A_UCLR = 8'h84, A_FLAG = 8'h86;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic bus_we = 1'b0;
  logic [7:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [NCH-1:0] req = '0;
  logic fiq, irq;
  logic [SW-1:0] slot;
  logic [31:0] vec;

  int nchk = 0;
  int nerr = 0;

  always #2 clk = ~clk;

  intr_vector_mgr #(.NCH(NCH), .ADDR_W(8)) dut (
    .clk(clk), .rst(rst), .bus_we(bus_we), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .req_i(req),
    .fiq_o(fiq), .irq_o(irq), .irq_slot_o(slot), .irq_vec_o(vec)
  );

  function automatic logic [31:0] tv(input int i);
    return 32'h8000_0000 | (32'(i) << 4) | 32'(i % 3);
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nerr++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk); bus_we = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk); bus_we = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk); bus_addr = a;
    @(negedge clk); d = bus_rdata;
  endtask

  task automatic pulse(input int ch);
    @(negedge clk); req[ch] = 1'b1;
    @(negedge clk); req[ch] = 1'b0;
  endtask

  task automatic summary;
    $display("  Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    nchk++; nerr++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    summary();
  end

  initial begin
    logic [31:0] d;
    repeat (5) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R11 reset state
    chk("R11 fiq", 32'(fiq), 0);
    chk("R11 irq", 32'(irq), 0);
    chk("R11 slot", 32'(slot), 0);
    rd(A_FLAG, d);      chk("R11 flags low", d, 0);
    rd(A_USET, d);      chk("R11 unmask low", d, 32'h3);
    rd(A_UCLR + 1, d);  chk("R11 unmask high", d, 0);
    rd(A_ROUTE, d);     chk("R5 route reset low", d, 32'h3);
    rd(A_ROUTE + 1, d); chk("R5 route reset high", d, 0);

    // R10 table load and readback
    for (int i = 0; i <= NCH; i++) wr(8'(i), tv(i));
    for (int i = 0; i <= NCH; i++) begin
      rd(8'(i), d); chk($sformatf("R10 table word %0d", i), d, tv(i));
    end
    @(negedge clk);
    chk("R9 idle vector", vec, tv(0));

    // per-channel sweep over the normal queue
    for (int c = 2; c < NCH; c++) begin
      logic [7:0] wofs;
      logic [31:0] bit_c;
      wofs = 8'(c / 32);
      bit_c = 32'h1 << (c % 32);
      wr(A_USET + wofs, bit_c);
      pulse(c);
      chk($sformatf("R7 latency ch%0d", c), 32'(irq), 0);
      @(negedge clk);
      chk($sformatf("R7 irq ch%0d", c), 32'(irq), 1);
      chk($sformatf("R8 slot ch%0d", c), 32'(slot), 32'(c + 1));
      chk($sformatf("R9 vec ch%0d", c), vec, tv(c + 1));
      chk($sformatf("R5 no fiq ch%0d", c), 32'(fiq), 0);
      rd(A_FLAG + wofs, d);
      chk($sformatf("R1 flag ch%0d", c), d, bit_c);
      wr(A_FLAG + wofs, bit_c);
      @(negedge clk);
      chk($sformatf("R2 cleared ch%0d", c), 32'(irq), 0);
      chk($sformatf("R8 idle slot ch%0d", c), 32'(slot), 0);
      chk($sformatf("R9 idle vec ch%0d", c), vec, tv(0));
      wr(A_UCLR + wofs, bit_c);
    end

    // R3 set/clear semantics, zero writes change nothing
    wr(A_USET, 32'hFFFF_FFFF);
    wr(A_USET + 1, 32'hFFFF_FFFF);
    wr(A_UCLR, 32'h0);
    wr(A_USET + 1, 32'h0);
    rd(A_UCLR, d);     chk("R3 all unmasked low", d, 32'hFFFF_FFFF);
    rd(A_USET + 1, d); chk("R3 all unmasked high", d, 32'hFFFF_FFFF);

    // R8 priority: fire channels 2..63 together, acknowledge winners in order
    @(negedge clk); req = {{(NCH-2){1'b1}}, 2'b00};
    @(negedge clk); req = '0;
    @(negedge clk);
    for (int c = 2; c < NCH; c++) begin
      chk($sformatf("R8 priority winner %0d", c), 32'(slot), 32'(c + 1));
      chk($sformatf("R9 priority vec %0d", c), vec, tv(c + 1));
      wr(A_FLAG + 8'(c / 32), 32'h1 << (c % 32));
      @(negedge clk);
    end
    chk("R8 priority drained", 32'(irq), 0);

    // R6 masked channel latches but stays quiet
    wr(A_UCLR, 32'h1 << 20);
    rd(A_USET, d); chk("R3 mask clear bit20", d, 32'hFFEF_FFFF);
    pulse(20);
    @(negedge clk);
    chk("R6 masked no irq", 32'(irq), 0);
    rd(A_FLAG, d); chk("R6 masked flag kept", d, 32'h1 << 20);
    wr(A_USET, 32'h1 << 20);
    @(negedge clk);
    chk("R6 late unmask irq", 32'(irq), 1);
    chk("R6 late unmask slot", 32'(slot), 21);
    wr(A_FLAG, 32'h1 << 20);

    // R5 fast routing
    wr(A_ROUTE + 1, 32'h1 << 8);
    pulse(40);
    @(negedge clk);
    chk("R5 fast ch40 fiq", 32'(fiq), 1);
    chk("R5 fast ch40 irq", 32'(irq), 0);
    chk("R5 fast ch40 slot", 32'(slot), 0);
    wr(A_FLAG + 1, 32'h1 << 8);
    @(negedge clk);
    chk("R7 fiq drops", 32'(fiq), 0);
    wr(A_ROUTE + 1, 32'h0);

    // R4 fixed channels
    wr(A_ROUTE, 32'h0);
    wr(A_UCLR, 32'h3);
    rd(A_ROUTE, d); chk("R4 route fixed", d & 32'h3, 32'h3);
    rd(A_USET, d);  chk("R4 unmask fixed", d & 32'h3, 32'h3);
    pulse(0);
    @(negedge clk);
    chk("R4 ch0 fiq", 32'(fiq), 1);
    chk("R4 ch0 no irq", 32'(irq), 0);
    wr(A_FLAG, 32'h1);
    @(negedge clk);
    chk("R4 ch0 cleared", 32'(fiq), 0);

    // R1 held level sets only once
    @(negedge clk); req[30] = 1'b1;
    repeat (3) @(negedge clk);
    chk("R1 held irq", 32'(irq), 1);
    wr(A_FLAG, 32'h1 << 30);
    repeat (3) @(negedge clk);
    chk("R1 held no reset", 32'(irq), 0);
    rd(A_FLAG, d); chk("R1 held flag clear", d, 0);
    req[30] = 1'b0;
    @(negedge clk);

    // R2 new edge in the acknowledge cycle keeps the flag
    pulse(30);
    @(negedge clk);
    req[30] = 1'b1; bus_we = 1'b1; bus_addr = A_FLAG; bus_wdata = 32'h1 << 30;
    @(negedge clk);
    bus_we = 1'b0;
    @(negedge clk);
    chk("R2 edge beats clear irq", 32'(irq), 1);
    rd(A_FLAG, d); chk("R2 edge beats clear flag", d, 32'h1 << 30);
    wr(A_FLAG, 32'h0);
    rd(A_FLAG, d); chk("R2 zero write keeps", d, 32'h1 << 30);
    req[30] = 1'b0;
    wr(A_FLAG, 32'h1 << 30);
    @(negedge clk);
    chk("R2 final clear", 32'(irq), 0);

    summary();
  end
endmodule